// File: doc/BRIEF.md
# Watchdog Timer with Tick Prescaler on an APB Slave

This block supervises software by counting down towards a reset. Software programs a start value and enables the countdown. A prescaler turns a free-running reference clock-enable into slower ticks, and each tick removes two from the 24-bit count. If software stops reloading the count and it runs out, the block raises a one-cycle reset request. Software can also force that request at once through a self-clearing control bit. A cause register records whether the last request came from expiry or from a forced trigger. The cause register is only updated by a new request or cleared by a hard reset.

Three pause inputs can freeze the countdown: one for each of two processors halted in debug, and one for an external debug probe driving the bus. Each input has its own mask bit. Eight general-purpose keep registers hold data across the soft reset that the request normally leads to. Choosing which subsystems get reset is left to the surrounding reset controller.

All accesses are zero-wait APB transfers. There is a synchronous active-high hard reset, which clears everything. There is also a synchronous soft reset, which clears the control, reload and prescaler state but spares the keep registers and the cause register.

Top module: `wdog_apb_top`

## Requirements
- R1: Register words sit at byte offsets 0x00 control, 0x04 reload, 0x08 cause, 0x0C to 0x28 the eight keep registers, and 0x2C prescaler. Reads of the reload word, of any other offset, or of an address whose two low bits are not zero return 0, and writes to those places change nothing. pready is always 1 and pslverr is always 0.
- R2: A write to the reload word places bits 23:0 into the countdown. The count then reads back in control bits 23:0.
- R3: While control bit 30 (enable) is 1 and no masked pause is active, each tick lowers the count by 2. While enable is 0, the count holds.
- R4: Control bits 26, 25 and 24 are pause masks for processor 1 debug, processor 0 debug and probe bus access. An input freezes the count only while its mask bit is 1.
- R5: When a tick finds the count at 2 or less, the count goes to 0. The first such event after a reload write gives exactly one rst_req pulse and sets cause to 0x1. Later ticks give no further pulse until the next reload write.
- R6: Writing control with bit 31 set gives one rst_req pulse and sets cause to 0x2. Bit 31 always reads 0, and the same write also updates enable and the masks.
- R7: The prescaler word holds CYCLES in bits 8:0, tick enable in bit 9, running in bit 10 (equal to tick enable) and the remaining count in bits 19:11. A write restarts the remaining count from the new CYCLES. Each reference enable lowers the remaining count by one. When it is at 1 or less, it emits a tick and reloads from CYCLES. With tick enable 0, no ticks occur and the remaining count holds.
- R8: After a hard reset, control reads 0x0700_0000, the prescaler word reads 0x0000_0600, and cause and every keep register read 0.
- R9: A soft reset returns control, the countdown and the prescaler to their hard-reset values. The keep registers and cause keep their contents.
- R10: Each keep register is 32-bit read/write.
- R11: Writes to read-only fields are ignored. This covers control bits 23:0 and the cause word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, clears all state |
| soft_rst | input | 1 | Synchronous soft reset, spares keep and cause registers |
| ref_tick_en | input | 1 | Reference clock-enable fed to the prescaler |
| dbg_halt_p0 | input | 1 | Processor 0 is halted in debug |
| dbg_halt_p1 | input | 1 | Processor 1 is halted in debug |
| probe_active | input | 1 | External debug probe is accessing the bus |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench covers expiry from counts that are not multiples of two and from a count of exactly 2. A design that checks only for zero would wrap to a huge value and never request a reset. It also ticks past expiry and requires no second pulse, which catches a design that keeps re-firing from a count of zero. The pause tests use unmasked inputs that are active at the same time as masked ones, to catch masks wired to the wrong input. A soft reset after data has been stored in a keep register and in cause catches a design that clears either one, or that fails to clear control and the prescaler.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // word indices of the fixed registers (byte offset / 4)
  localparam int IDX_CTRL   = 0;
  localparam int IDX_LOAD   = 1;
  localparam int IDX_CAUSE  = 2;
  localparam int IDX_KEEP0  = 3;
  // control word bit positions that software decodes
  localparam int CTRL_FORCE_BIT = 31;
  localparam int CTRL_EN_BIT    = 30;
  localparam int CTRL_MASK_LSB  = 24;  // [2]=proc1, [1]=proc0, [0]=probe
  localparam int MASK_W         = 3;
  // cause encoding
  localparam logic [1:0] CAUSE_TIMER = 2'b01;
  localparam logic [1:0] CAUSE_FORCE = 2'b10;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int PRE_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_en,
  input  logic             cfg_en,
  input  logic [PRE_W-1:0] cfg_cycles,
  input  logic             restart,
  input  logic [PRE_W-1:0] restart_val,
  output logic             tick_q,
  output logic [PRE_W-1:0] remain_q
);
  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      tick_q   <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (restart) begin
        remain_q <= restart_val;
      end else if (cfg_en && ref_en) begin
        if (remain_q <= ONE) begin
          tick_q   <= 1'b1;
          remain_q <= cfg_cycles;
        end else begin
          remain_q <= remain_q - ONE;
        end
      end
    end
  end

  // R7: a disabled prescaler emits no tick on the following cycle
  assert_no_tick_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> !tick_q);
  // R7: with no reference enable and no restart, the remaining count holds
  assert_remain_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!ref_en && !restart) |=> $stable(remain_q));
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CNT_W = 24,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire_q
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (load) begin
        cnt_q   <= load_val;
        armed_q <= 1'b1;
      end else if (tick && run) begin
        if (cnt_q <= STEP_V) begin
          cnt_q   <= '0;
          armed_q <= 1'b0;
          if (armed_q) expire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - STEP_V;
        end
      end
    end
  end

  // R3: an active tick above the floor lowers the count by exactly STEP
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !load && cnt_q > STEP_V) |=> (cnt_q == $past(cnt_q) - STEP_V));
  // R3/R4: without load or an unpaused tick the count is frozen
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && !(tick && run)) |=> $stable(cnt_q));
  // R5: expiry leaves the count at zero and lasts one cycle
  assert_expire_zero_R5: assert property (@(posedge clk) disable iff (rst)
    expire_q |-> (cnt_q == '0));
  assert_expire_single_R5: assert property (@(posedge clk) disable iff (rst)
    expire_q |=> !expire_q);
endmodule

// File: rtl/wdog_apb_regs.sv
module wdog_apb_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 24,
  parameter int PRE_W    = 9,
  parameter int NUM_KEEP = 8
) (
  input  logic              clk,
  input  logic              hard_rst,
  input  logic              soft_rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [PRE_W-1:0]  remain,
  input  logic              expire,
  output logic              ctrl_en,
  output logic [MASK_W-1:0] pause_mask,
  output logic              tick_en,
  output logic [PRE_W-1:0]  tick_cycles,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic              tick_restart,
  output logic [PRE_W-1:0]  restart_val,
  output logic              force_q
);
  localparam int WORD_W   = ADDR_W - 2;
  localparam int TICK_IDX = IDX_KEEP0 + NUM_KEEP;

  logic [WORD_W-1:0] word;
  logic              aligned, wr_acc, rd_setup;
  logic [1:0]        cause_q;
  logic [DATA_W-1:0] keep_mem [NUM_KEEP];
  logic [DATA_W-1:0] rd_mux;

  assign word     = paddr[ADDR_W-1:2];
  assign aligned  = (paddr[1:0] == 2'b00);
  assign wr_acc   = psel && penable && pwrite && aligned;
  assign rd_setup = psel && !penable;

  assign load_stb     = wr_acc && (word == WORD_W'(IDX_LOAD));
  assign load_val     = pwdata[CNT_W-1:0];
  assign tick_restart = wr_acc && (word == WORD_W'(TICK_IDX));
  assign restart_val  = pwdata[PRE_W-1:0];

  // control and prescaler configuration: cleared by either reset
  always_ff @(posedge clk) begin
    if (hard_rst || soft_rst) begin
      ctrl_en     <= 1'b0;
      pause_mask  <= '1;
      force_q     <= 1'b0;
      tick_en     <= 1'b1;
      tick_cycles <= '0;
    end else begin
      force_q <= 1'b0;
      if (wr_acc && word == WORD_W'(IDX_CTRL)) begin
        ctrl_en    <= pwdata[CTRL_EN_BIT];
        pause_mask <= pwdata[CTRL_MASK_LSB +: MASK_W];
        force_q    <= pwdata[CTRL_FORCE_BIT];
      end
      if (tick_restart) begin
        tick_en     <= pwdata[PRE_W];
        tick_cycles <= pwdata[PRE_W-1:0];
      end
    end
  end

  // cause and keep registers: only a hard reset clears them
  always_ff @(posedge clk) begin
    if (hard_rst) begin
      cause_q <= '0;
      for (int k = 0; k < NUM_KEEP; k++) keep_mem[k] <= '0;
    end else begin
      if (force_q || expire) cause_q <= {force_q, expire};
      for (int k = 0; k < NUM_KEEP; k++)
        if (wr_acc && word == WORD_W'(IDX_KEEP0 + k)) keep_mem[k] <= pwdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (word == WORD_W'(IDX_CTRL)) begin
        rd_mux[CNT_W-1:0]                    = cnt;
        rd_mux[CTRL_MASK_LSB +: MASK_W]      = pause_mask;
        rd_mux[CTRL_EN_BIT]                  = ctrl_en;
      end else if (word == WORD_W'(IDX_CAUSE)) begin
        rd_mux[1:0] = cause_q;
      end else if (word == WORD_W'(TICK_IDX)) begin
        rd_mux[PRE_W-1:0]             = tick_cycles;
        rd_mux[PRE_W]                 = tick_en;
        rd_mux[PRE_W+1]               = tick_en;
        rd_mux[PRE_W+2 +: PRE_W]      = remain;
      end
      for (int k = 0; k < NUM_KEEP; k++)
        if (word == WORD_W'(IDX_KEEP0 + k)) rd_mux = keep_mem[k];
    end
  end

  // read data registered in the setup phase, valid through the access phase
  always_ff @(posedge clk) begin
    if (hard_rst || soft_rst) prdata <= '0;
    else if (rd_setup)        prdata <= rd_mux;
  end

  // R6: a forced trigger records the forced cause
  assert_force_cause_R6: assert property (@(posedge clk) disable iff (hard_rst)
    force_q |=> (cause_q == CAUSE_FORCE || cause_q == (CAUSE_FORCE | CAUSE_TIMER)));
  // R5: a lone expiry records the timer cause
  assert_timer_cause_R5: assert property (@(posedge clk) disable iff (hard_rst)
    (expire && !force_q) |=> (cause_q == CAUSE_TIMER));
  // R9: a soft reset does not touch the cause register
  assert_soft_keeps_cause_R9: assert property (@(posedge clk) disable iff (hard_rst)
    (soft_rst && !force_q && !expire) |=> $stable(cause_q));
endmodule

// File: rtl/wdog_apb_top.sv
module wdog_apb_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 24,
  parameter int PRE_W    = 9,
  parameter int NUM_KEEP = 8,
  parameter int STEP     = 2
) (
  input  logic              clk,
  input  logic              hard_rst,
  input  logic              soft_rst,
  input  logic              ref_tick_en,
  input  logic              dbg_halt_p0,
  input  logic              dbg_halt_p1,
  input  logic              probe_active,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              rst_req
);
  logic              blk_rst;
  logic              ctrl_en, tick_en, load_stb, tick_restart, force_q;
  logic [MASK_W-1:0] pause_mask;
  logic [PRE_W-1:0]  tick_cycles, restart_val, remain;
  logic [CNT_W-1:0]  load_val, cnt;
  logic              tick, expire, paused;

  assign blk_rst = hard_rst || soft_rst;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign paused  = |(pause_mask & {dbg_halt_p1, dbg_halt_p0, probe_active});

  wdog_apb_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .PRE_W(PRE_W), .NUM_KEEP(NUM_KEEP)
  ) regs_i (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .cnt(cnt), .remain(remain), .expire(expire),
    .ctrl_en(ctrl_en), .pause_mask(pause_mask),
    .tick_en(tick_en), .tick_cycles(tick_cycles),
    .load_stb(load_stb), .load_val(load_val),
    .tick_restart(tick_restart), .restart_val(restart_val),
    .force_q(force_q)
  );

  wdog_tick_gen #(.PRE_W(PRE_W)) tick_i (
    .clk(clk), .rst(blk_rst), .ref_en(ref_tick_en),
    .cfg_en(tick_en), .cfg_cycles(tick_cycles),
    .restart(tick_restart), .restart_val(restart_val),
    .tick_q(tick), .remain_q(remain)
  );

  wdog_countdown #(.CNT_W(CNT_W), .STEP(STEP)) cnt_i (
    .clk(clk), .rst(blk_rst), .load(load_stb), .load_val(load_val),
    .tick(tick), .run(ctrl_en && !paused),
    .cnt_q(cnt), .expire_q(expire)
  );

  always_ff @(posedge clk) begin
    if (blk_rst) rst_req <= 1'b0;
    else         rst_req <= expire || force_q;
  end

  // R5/R6: every expiry or forced trigger reaches the request output
  assert_req_follows_R6: assert property (@(posedge clk) disable iff (blk_rst)
    (expire || force_q) |=> rst_req);
  // R5/R6: no request without a cause one cycle earlier
  assert_req_has_cause_R5: assert property (@(posedge clk) disable iff (blk_rst)
    (!expire && !force_q) |=> !rst_req);
endmodule

// File: tb/wdog_apb_top_tb.sv
module wdog_apb_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        hard_rst, soft_rst, ref_tick_en;
  logic        dbg_halt_p0, dbg_halt_p1, probe_active;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, pslverr, rst_req;

  int n_tests = 0;
  int n_fail  = 0;
  int req_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_apb_top dut_i (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .ref_tick_en(ref_tick_en), .dbg_halt_p0(dbg_halt_p0),
    .dbg_halt_p1(dbg_halt_p1), .probe_active(probe_active),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .rst_req(rst_req)
  );

  always @(negedge clk) if (rst_req === 1'b1) req_seen++;

  // vector table: op (1 write, 0 read), address, data, expected read, requirement
  localparam logic       V_OP   [NV] = '{0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 1, 0};
  localparam logic [7:0] V_ADDR [NV] = '{8'h00, 8'h2C, 8'h08, 8'h04, 8'h0C, 8'h28,
                                         8'h0C, 8'h28, 8'h30, 8'h0E, 8'h08, 8'h08};
  localparam logic [31:0] V_DATA [NV] = '{0, 0, 0, 0, 32'hDEADBEEF, 32'h12345678,
                                          0, 0, 0, 0, 32'h3, 0};
  localparam logic [31:0] V_EXP  [NV] = '{32'h0700_0000, 32'h0000_0600, 0, 0, 0, 0,
                                          32'hDEADBEEF, 32'h12345678, 0, 0, 0, 0};
  localparam int          V_REQ  [NV] = '{8, 8, 8, 1, 10, 10, 10, 10, 1, 1, 11, 11};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ref_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick_en = 1'b1;
      @(negedge clk); ref_tick_en = 1'b0;
      idle(5);
    end
  endtask

  task automatic do_reset(input bit hard);
    @(negedge clk);
    if (hard) hard_rst = 1'b1; else soft_rst = 1'b1;
    @(negedge clk);
    hard_rst = 1'b0; soft_rst = 1'b0;
    idle(2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int base;
    hard_rst = 1'b1; soft_rst = 1'b0; ref_tick_en = 1'b0;
    dbg_halt_p0 = 1'b0; dbg_halt_p1 = 1'b0; probe_active = 1'b0;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    idle(3);
    hard_rst = 1'b0;
    idle(2);
    check("R1 pready", {31'b0, pready}, 32'h1);
    check("R1 pslverr", {31'b0, pslverr}, 32'h0);

    // table walk: reset values (R8), map and unmapped reads (R1), keep RW (R10), RO cause (R11)
    for (int v = 0; v < NV; v++) begin
      if (V_OP[v]) apb_write(V_ADDR[v], V_DATA[v]);
      else begin
        apb_read(V_ADDR[v], rd);
        check($sformatf("R%0d vector %0d", V_REQ[v], v), rd, V_EXP[v]);
      end
    end

    // R7: prescaler restart and remaining count
    apb_write(8'h2C, 32'h0000_0203);
    apb_read(8'h2C, rd); check("R7 tick restart", rd, 32'h0000_1E03);
    ref_pulse(1);
    apb_read(8'h2C, rd); check("R7 tick remain", rd, 32'h0000_1603);
    apb_write(8'h2C, 32'h0000_0201);

    // R2: load value visible in control
    apb_write(8'h04, 32'h0000_0064);
    apb_read(8'h00, rd); check("R2 load", rd, 32'h0700_0064);
    // R3: disabled countdown holds
    ref_pulse(3);
    apb_read(8'h00, rd); check("R3 hold when disabled", rd, 32'h0700_0064);
    // R3: enabled, masks clear, count drops by 2 per tick
    apb_write(8'h00, 32'h4000_0000);
    ref_pulse(3);
    apb_read(8'h00, rd); check("R3 step by two", rd, 32'h4000_005E);
    // R11: write to count field ignored
    apb_write(8'h00, 32'h4000_0005);
    apb_read(8'h00, rd); check("R11 count read-only", rd, 32'h4000_005E);

    // R4: pause masks
    apb_write(8'h00, 32'h4400_0000);
    dbg_halt_p1 = 1'b1;
    ref_pulse(2);
    apb_read(8'h00, rd); check("R4 proc1 pause", rd, 32'h4400_005E);
    dbg_halt_p1 = 1'b0; dbg_halt_p0 = 1'b1; probe_active = 1'b1;
    ref_pulse(1);
    apb_read(8'h00, rd); check("R4 unmasked inputs", rd, 32'h4400_005C);
    apb_write(8'h00, 32'h4100_0000);
    ref_pulse(1);
    apb_read(8'h00, rd); check("R4 probe pause", rd, 32'h4100_005C);
    probe_active = 1'b0;
    ref_pulse(1);
    apb_read(8'h00, rd); check("R4 probe released", rd, 32'h4100_005A);
    dbg_halt_p0 = 1'b0;

    // R5: expiry from an odd count
    base = req_seen;
    apb_write(8'h04, 32'h0000_0005);
    ref_pulse(2);
    apb_read(8'h00, rd); check("R5 before expiry", rd, 32'h4100_0001);
    check("R5 no early request", req_seen - base, 0);
    ref_pulse(1);
    apb_read(8'h00, rd); check("R5 saturate zero", rd, 32'h4100_0000);
    check("R5 one request", req_seen - base, 1);
    apb_read(8'h08, rd); check("R5 timer cause", rd, 32'h1);
    ref_pulse(2);
    check("R5 no repeat request", req_seen - base, 1);
    apb_write(8'h04, 32'h0000_0002);
    ref_pulse(1);
    check("R5 rearm after load, count 2", req_seen - base, 2);

    // R6: forced trigger
    apb_write(8'h00, 32'h8000_0000);
    idle(4);
    check("R6 forced request", req_seen - base, 3);
    apb_read(8'h00, rd); check("R6 trigger reads zero", rd, 32'h0000_0000);
    apb_read(8'h08, rd); check("R6 force cause", rd, 32'h2);

    // R9: soft reset keeps keep registers and cause, clears the rest
    apb_write(8'h18, 32'hCAFEF00D);
    apb_write(8'h2C, 32'h0000_0005);
    apb_write(8'h00, 32'h4000_0000);
    do_reset(1'b0);
    apb_read(8'h18, rd); check("R9 keep survives", rd, 32'hCAFEF00D);
    apb_read(8'h08, rd); check("R9 cause survives", rd, 32'h2);
    apb_read(8'h00, rd); check("R9 control cleared", rd, 32'h0700_0000);
    apb_read(8'h2C, rd); check("R9 prescaler cleared", rd, 32'h0000_0600);

    // R8: hard reset clears keep and cause
    do_reset(1'b1);
    apb_read(8'h18, rd); check("R8 keep cleared", rd, 32'h0);
    apb_read(8'h08, rd); check("R8 cause cleared", rd, 32'h0);

    // R7: tick enable off stops the countdown
    apb_write(8'h2C, 32'h0000_0001);
    apb_read(8'h2C, rd); check("R7 not running", rd, 32'h0000_0801);
    apb_write(8'h04, 32'h0000_0032);
    apb_write(8'h00, 32'h4000_0000);
    ref_pulse(2);
    apb_read(8'h00, rd); check("R7 no ticks when off", rd, 32'h4000_0032);
    apb_read(8'h2C, rd); check("R7 remain holds", rd, 32'h0000_0801);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule